// File: doc/BRIEF.md
# Linear Chi-Square Track Fit Pipeline

This block scores one candidate track per clock cycle. A candidate is a set of 11 signed hit coordinates from one road. The block also receives the constant matrix of that candidate's sector. It forms six fit components, one per matrix row. Each component is the dot product of the row with the coordinate vector, extended by a constant element equal to one, so the last column of each row acts as an additive offset. Each sum is rescaled by an arithmetic right shift and narrowed back to 27 bits. The six narrowed components are squared and summed. The result is compared against a track threshold. A candidate passes only when it is valid, when no narrowing stage lost information, and when its chi-square is strictly below the threshold.

The pipeline takes a new candidate on every cycle and never stalls. A sideband delay line carries each candidate's sector identifier, layer map and raw hit words through the same number of stages as the arithmetic. The pass strobe can therefore serve directly as the write enable of a downstream track buffer, with the matching candidate data present on the same cycle. The threshold is held in a register that is loaded from a configuration port while no candidate is in flight.

Top module: `fit_chi2_pipe`

## Requirements
- R1: Coordinate j (0..10) sits at `coord_i[j*27 +: 27]`. Element 11 of the input vector is the constant 1, supplied inside the block. Row r, element j of the constants sits at `coef_i[(r*12+j)*27 +: 27]`. All values are two's complement. Component r before rescaling is the exact signed sum of the 12 products.
- R2: Each component sum is arithmetically shifted right by `SHIFT` bits (default 8, so the result is rounded toward minus infinity). The low 27 bits of the shifted value form the narrowed component.
- R3: A narrowing overflows when the shifted value lies outside [-2^26, 2^26-1]. `ovf_o` is high for a valid candidate when any of its six components overflowed.
- R4: `chi2_o` is the 57-bit unsigned sum of the squares of the six narrowed components, with truncated values used even when an overflow occurred.
- R5: `pass_o` is high exactly when the candidate is valid, has no overflow, and has `chi2_o` strictly less than the threshold. A chi-square equal to the threshold fails.
- R6: A candidate captured at a rising edge produces `out_valid_o`, `pass_o`, `ovf_o` and `chi2_o` after the tenth rising edge, counting the capture edge. A new candidate is accepted on every cycle with no stall.
- R7: `sector_o`, `layers_o` and `hits_o` show the values captured with the candidate, on the same cycle as its result.
- R8: A cycle with `in_valid_i` low produces `out_valid_o` and `pass_o` low ten edges later, whatever the data inputs carried.
- R9: The threshold register resets to 0, so nothing passes until a threshold is loaded. It takes `thr_i` at an edge where `thr_load_i` is high. A load is only allowed when the current cycle and the previous ten cycles carried no valid candidate.
- R10: Reset is synchronous and active low. It clears `out_valid_o`, `pass_o`, `ovf_o` and `chi2_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Candidate on the inputs is valid this cycle |
| coord_i | input | 297 | 11 signed 27-bit hit coordinates |
| coef_i | input | 1944 | 6 rows of 12 signed 27-bit sector constants |
| sector_i | input | 16 | Sector identifier, carried as sideband |
| layers_i | input | 8 | Layer map, carried as sideband |
| hits_i | input | 176 | Raw hit words, carried as sideband |
| thr_load_i | input | 1 | Load `thr_i` into the threshold register |
| thr_i | input | 57 | New threshold value |
| out_valid_o | output | 1 | A candidate's result is on the outputs |
| pass_o | output | 1 | Candidate accepted as a track (buffer write enable) |
| ovf_o | output | 1 | A narrowing stage overflowed for this candidate |
| chi2_o | output | 57 | Sum of squared components |
| sector_o | output | 16 | Sector identifier aligned with the result |
| layers_o | output | 8 | Layer map aligned with the result |
| hits_o | output | 176 | Hit words aligned with the result |

## Verification
Every result and every sideband field of a candidate is due ten rising edges after the edge that captures it: three multiply stages, two adder stages, one narrowing stage, two squaring stages and two stages for the sum and compare. The bench drives one candidate at each falling edge. It stores the expected result in a small ring indexed by drive step. At each falling edge, before driving the next candidate, it compares the outputs against the entry written ten steps earlier. Because of this, back-to-back candidates, gaps and idle cycles are all checked at their exact due cycle. Threshold loads are placed only after at least eleven idle cycles, so the expected pass value computed at drive time uses the threshold that the hardware will hold when that candidate reaches the compare.

// File: rtl/fit_pkg.sv
// Shared widths and stage counts for the chi-square fit pipeline.
// Assumes 11 coordinates, one constant element and six fit components.
package fit_pkg;
    localparam int unsigned N_COORD  = 11;
    localparam int unsigned N_TERM   = N_COORD + 1;
    localparam int unsigned N_COMP   = 6;
    localparam int unsigned VAL_W    = 27;
    localparam int unsigned PROD_W   = 2 * VAL_W;
    localparam int unsigned SUM_W    = PROD_W + 4;
    localparam int unsigned SQ_W     = 2 * VAL_W;
    localparam int unsigned CHI_W    = SQ_W + 3;
    localparam int unsigned GRP_N    = 3;
    localparam int unsigned GRP_SIZE = N_TERM / GRP_N;
    localparam int unsigned ROW_LAT  = 6;
    localparam int unsigned TAIL_LAT = 4;
    localparam int unsigned PIPE_LAT = ROW_LAT + TAIL_LAT;
endpackage

// File: rtl/fit_dot_row.sv
// One fit component: multiplies the 12-element input vector by one constant
// row, sums the products, then shifts and narrows the sum to 27 bits.
// Latency is ROW_LAT cycles: three multiply, two add, one narrow.
// Assumes the twelfth input element is the constant 1, supplied here.
module fit_dot_row
    import fit_pkg::*;
#(
    parameter int unsigned SHIFT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_COORD*VAL_W-1:0]      coord_i,
    input  logic [N_TERM*VAL_W-1:0]       coef_i,
    output logic signed [VAL_W-1:0]       comp_o,
    output logic                          ovf_o
);
    logic signed [VAL_W-1:0]  x_q   [N_TERM];
    logic signed [VAL_W-1:0]  k_q   [N_TERM];
    logic signed [PROD_W-1:0] p_q   [N_TERM];
    logic signed [PROD_W-1:0] p2_q  [N_TERM];
    logic signed [SUM_W-1:0]  grp_d [GRP_N];
    logic signed [SUM_W-1:0]  grp_q [GRP_N];
    logic signed [SUM_W-1:0]  sum_d;
    logic signed [SUM_W-1:0]  sum_q;
    logic signed [SUM_W-1:0]  shifted;
    logic                     fits;

    // Capture operands, appending the constant element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N_TERM; j++) begin
                x_q[j] <= '0;
                k_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < N_COORD; j++) begin
                x_q[j] <= coord_i[j*VAL_W +: VAL_W];
            end
            x_q[N_COORD] <= VAL_W'(1);
            for (int j = 0; j < N_TERM; j++) begin
                k_q[j] <= coef_i[j*VAL_W +: VAL_W];
            end
        end
    end

    // Form the signed products and retime them by one extra stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N_TERM; j++) begin
                p_q[j]  <= '0;
                p2_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < N_TERM; j++) begin
                p_q[j]  <= PROD_W'(x_q[j]) * PROD_W'(k_q[j]);
                p2_q[j] <= p_q[j];
            end
        end
    end

    // Partial sums over groups of products.
    always_comb begin
        for (int g = 0; g < GRP_N; g++) begin
            grp_d[g] = '0;
            for (int i = 0; i < GRP_SIZE; i++) begin
                grp_d[g] = grp_d[g] + SUM_W'(p2_q[g*GRP_SIZE + i]);
            end
        end
    end

    // Final sum of the group partials.
    always_comb begin
        sum_d = '0;
        for (int g = 0; g < GRP_N; g++) begin
            sum_d = sum_d + grp_q[g];
        end
    end

    // Register both adder levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < GRP_N; g++) begin
                grp_q[g] <= '0;
            end
            sum_q <= '0;
        end else begin
            grp_q <= grp_d;
            sum_q <= sum_d;
        end
    end

    // Rescale and test whether the upper bits are pure sign extension.
    always_comb begin
        shifted = sum_q >>> SHIFT;
        fits    = (&shifted[SUM_W-1:VAL_W-1]) | ~(|shifted[SUM_W-1:VAL_W-1]);
    end

    // Register the narrowed component and its overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_o <= '0;
            ovf_o  <= 1'b0;
        end else begin
            comp_o <= shifted[VAL_W-1:0];
            ovf_o  <= ~fits;
        end
    end

    // R2 R3
    narrow_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_o || (SUM_W'(comp_o) == ($past(sum_q) >>> SHIFT))));
endmodule

// File: rtl/fit_chi_sum.sv
// Squares the six narrowed components, sums the squares, and compares the
// total with the threshold. Latency is TAIL_LAT cycles. Assumes the threshold
// input stays constant while valid candidates are in flight.
module fit_chi_sum
    import fit_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_COMP*VAL_W-1:0]      comp_i,
    input  logic                         ovf_i,
    input  logic                         vld_i,
    input  logic [CHI_W-1:0]             thr_i,
    output logic                         vld_o,
    output logic                         pass_o,
    output logic                         ovf_o,
    output logic [CHI_W-1:0]             chi2_o
);
    logic signed [VAL_W-1:0] comp_s [N_COMP];
    logic signed [SQ_W-1:0]  sq_d   [N_COMP];
    logic [SQ_W-1:0]         sq_q   [N_COMP];
    logic [SQ_W-1:0]         sq2_q  [N_COMP];
    logic [CHI_W-1:0]        tot_d;
    logic [CHI_W-1:0]        tot_q;
    logic                    v1_q, v2_q, v3_q;
    logic                    o1_q, o2_q, o3_q;

    // Unpack the components and square them.
    always_comb begin
        for (int r = 0; r < N_COMP; r++) begin
            comp_s[r] = comp_i[r*VAL_W +: VAL_W];
            sq_d[r]   = SQ_W'(comp_s[r]) * SQ_W'(comp_s[r]);
        end
    end

    // Sum the retimed squares.
    always_comb begin
        tot_d = '0;
        for (int r = 0; r < N_COMP; r++) begin
            tot_d = tot_d + CHI_W'(sq2_q[r]);
        end
    end

    // Square registers, retiming stage and summation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_COMP; r++) begin
                sq_q[r]  <= '0;
                sq2_q[r] <= '0;
            end
            tot_q <= '0;
            {v1_q, v2_q, v3_q} <= '0;
            {o1_q, o2_q, o3_q} <= '0;
        end else begin
            for (int r = 0; r < N_COMP; r++) begin
                sq_q[r]  <= sq_d[r];
                sq2_q[r] <= sq_q[r];
            end
            tot_q <= tot_d;
            {v1_q, v2_q, v3_q} <= {vld_i, v1_q, v2_q};
            {o1_q, o2_q, o3_q} <= {ovf_i, o1_q, o2_q};
        end
    end

    // Compare with the threshold and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            pass_o <= 1'b0;
            ovf_o  <= 1'b0;
            chi2_o <= '0;
        end else begin
            vld_o  <= v3_q;
            pass_o <= v3_q & ~o3_q & (tot_q < thr_i);
            ovf_o  <= v3_q & o3_q;
            chi2_o <= tot_q;
        end
    end

    // R5
    pass_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (vld_o && !ovf_o && (chi2_o < thr_i)));

    // R5
    pass_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !ovf_o && (chi2_o < thr_i)) |-> pass_o);
endmodule

// File: rtl/fit_side_delay.sv
// Fixed-depth delay line carrying candidate data beside the arithmetic.
// Assumes DEPTH is at least 1; every stage shifts on every cycle.
module fit_side_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage takes the block input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= d_i;
            end
        end else begin : g_body
            // Later stages take the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/fit_chi2_pipe.sv
// Top of the chi-square fit pipeline: six component rows, the square-and-sum
// tail, the threshold register and the matched sideband delay line.
// Accepts one candidate per cycle; results appear PIPE_LAT edges later.
// Assumes threshold loads happen only while no candidate is in flight.
module fit_chi2_pipe
    import fit_pkg::*;
#(
    parameter int unsigned SHIFT    = 8,
    parameter int unsigned SECTOR_W = 16,
    parameter int unsigned LAYER_W  = 8,
    parameter int unsigned HIT_W    = 176
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid_i,
    input  logic [N_COORD*VAL_W-1:0]      coord_i,
    input  logic [N_COMP*N_TERM*VAL_W-1:0] coef_i,
    input  logic [SECTOR_W-1:0]           sector_i,
    input  logic [LAYER_W-1:0]            layers_i,
    input  logic [HIT_W-1:0]              hits_i,
    input  logic                          thr_load_i,
    input  logic [CHI_W-1:0]              thr_i,
    output logic                          out_valid_o,
    output logic                          pass_o,
    output logic                          ovf_o,
    output logic [CHI_W-1:0]              chi2_o,
    output logic [SECTOR_W-1:0]           sector_o,
    output logic [LAYER_W-1:0]            layers_o,
    output logic [HIT_W-1:0]              hits_o
);
    localparam int unsigned ROW_BITS = N_TERM * VAL_W;
    localparam int unsigned SIDE_W   = SECTOR_W + LAYER_W + HIT_W;
    localparam int unsigned CNT_W    = $clog2(PIPE_LAT + 1);

    logic [N_COMP*VAL_W-1:0] comp_all;
    logic [N_COMP-1:0]       row_ovf;
    logic                    vld_q [ROW_LAT];
    logic [CHI_W-1:0]        thr_q;
    logic [CNT_W-1:0]        drain_q;
    logic [CNT_W-1:0]        age_q;

    for (genvar r = 0; r < N_COMP; r++) begin : g_row
        fit_dot_row #(.SHIFT(SHIFT)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .coord_i (coord_i),
            .coef_i  (coef_i[r*ROW_BITS +: ROW_BITS]),
            .comp_o  (comp_all[r*VAL_W +: VAL_W]),
            .ovf_o   (row_ovf[r])
        );
    end

    // Carry the valid bit alongside the component rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < ROW_LAT; s++) vld_q[s] <= 1'b0;
        end else begin
            vld_q[0] <= in_valid_i;
            for (int s = 1; s < ROW_LAT; s++) vld_q[s] <= vld_q[s-1];
        end
    end

    // Threshold register, loaded from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n)          thr_q <= '0;
        else if (thr_load_i) thr_q <= thr_i;
    end

    // Cycles until the pipeline holds no valid candidate.
    always_ff @(posedge clk) begin
        if (!rst_n)                drain_q <= '0;
        else if (in_valid_i)       drain_q <= CNT_W'(PIPE_LAT);
        else if (drain_q != '0)    drain_q <= drain_q - 1'b1;
    end

    // Edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                        age_q <= '0;
        else if (age_q != CNT_W'(PIPE_LAT)) age_q <= age_q + 1'b1;
    end

    fit_chi_sum u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .comp_i (comp_all),
        .ovf_i  (|row_ovf),
        .vld_i  (vld_q[ROW_LAT-1]),
        .thr_i  (thr_q),
        .vld_o  (out_valid_o),
        .pass_o (pass_o),
        .ovf_o  (ovf_o),
        .chi2_o (chi2_o)
    );

    fit_side_delay #(.WIDTH(SIDE_W), .DEPTH(PIPE_LAT)) u_side (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sector_i, layers_i, hits_i}),
        .q_o   ({sector_o, layers_o, hits_o})
    );

    // R6 R8
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == CNT_W'(PIPE_LAT)) |-> (out_valid_o == $past(in_valid_i, PIPE_LAT)));

    // R7
    side_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == CNT_W'(PIPE_LAT)) && out_valid_o) |-> (sector_o == $past(sector_i, PIPE_LAT)));

    // R9
    thr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load_i |-> ((drain_q == '0) && !in_valid_i));

    // R3 R5
    ovf_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !pass_o);
endmodule

// File: tb/fit_chi2_pipe_tb_top.sv
// Self-checking bench: streams candidates each cycle, models the arithmetic
// with 64-bit integers and compares every output ten edges after capture.
module fit_chi2_pipe_tb_top;
    import fit_pkg::*;

    localparam int SHIFT = 8;
    localparam int LAT   = 10;
    localparam int HIT_W = 176;

    logic                           clk = 1'b0;
    logic                           rst_n;
    logic                           in_valid_i;
    logic [N_COORD*VAL_W-1:0]       coord_i;
    logic [N_COMP*N_TERM*VAL_W-1:0] coef_i;
    logic [15:0]                    sector_i;
    logic [7:0]                     layers_i;
    logic [HIT_W-1:0]               hits_i;
    logic                           thr_load_i;
    logic [CHI_W-1:0]               thr_i;
    logic                           out_valid_o;
    logic                           pass_o;
    logic                           ovf_o;
    logic [CHI_W-1:0]               chi2_o;
    logic [15:0]                    sector_o;
    logic [7:0]                     layers_o;
    logic [HIT_W-1:0]               hits_o;

    // 50 MHz clock.
    always #10ns clk = ~clk;

    fit_chi2_pipe #(.SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
        .coord_i(coord_i), .coef_i(coef_i), .sector_i(sector_i),
        .layers_i(layers_i), .hits_i(hits_i), .thr_load_i(thr_load_i),
        .thr_i(thr_i), .out_valid_o(out_valid_o), .pass_o(pass_o),
        .ovf_o(ovf_o), .chi2_o(chi2_o), .sector_o(sector_o),
        .layers_o(layers_o), .hits_o(hits_o)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    int          cx [N_COORD];
    int          ck [N_COMP][N_TERM];
    longint      cur_thr = 0;
    int          stepn = 0;
    int unsigned seed = 32'h1234_5678;

    bit          rv [16];
    bit          rp [16];
    bit          ro [16];
    longint      rc [16];
    logic [15:0] rs [16];
    logic [7:0]  rl [16];
    logic [HIT_W-1:0] rh [16];

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int bits);
        int t;
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        t = int'(seed);
        t = (t <<< (32 - bits)) >>> (32 - bits);
        return t;
    endfunction

    task automatic clear_vec();
        for (int j = 0; j < N_COORD; j++) cx[j] = 0;
        for (int r = 0; r < N_COMP; r++)
            for (int j = 0; j < N_TERM; j++) ck[r][j] = 0;
    endtask

    task automatic rand_vec(input int xb, input int kb);
        for (int j = 0; j < N_COORD; j++) cx[j] = rnd(xb);
        for (int r = 0; r < N_COMP; r++)
            for (int j = 0; j < N_TERM; j++) ck[r][j] = rnd(kb);
    endtask

    // Compare outputs with the expectation stored LAT steps earlier.
    task automatic check_out();
        int idx;
        idx = (stepn - LAT) & 15;
        if (rv[idx]) begin
            chk("R6 out_valid", longint'(out_valid_o), 1);
            chk("R5 pass", longint'(pass_o), longint'(rp[idx]));
            chk("R3 ovf", longint'(ovf_o), longint'(ro[idx]));
            chk("R4 chi2", longint'(chi2_o), rc[idx]);
            chk("R7 sector", longint'(sector_o), longint'(rs[idx]));
            chk("R7 layers", longint'(layers_o), longint'(rl[idx]));
            checks++;
            if (hits_o !== rh[idx]) begin
                errors++;
                $display("FAIL R7 hits actual %h expected %h", hits_o, rh[idx]);
            end
        end else begin
            chk("R8 out_valid idle", longint'(out_valid_o), 0);
            chk("R8 pass idle", longint'(pass_o), 0);
        end
    endtask

    // One cycle: check due outputs, model and drive a candidate, advance.
    task automatic drive(input bit v, input bit ld, input longint thr);
        longint acc, sh, c, chi;
        bit     ov;
        int     idx;
        check_out();
        chi = 0;
        ov  = 1'b0;
        for (int r = 0; r < N_COMP; r++) begin
            acc = longint'(ck[r][N_COORD]);
            for (int j = 0; j < N_COORD; j++) acc += longint'(cx[j]) * longint'(ck[r][j]);
            sh = acc >>> SHIFT;
            if (sh > 64'sd67108863 || sh < -64'sd67108864) ov = 1'b1;
            c = (sh <<< 37) >>> 37;
            chi += c * c;
        end
        if (ld) cur_thr = thr;
        idx = stepn & 15;
        rv[idx] = v;
        ro[idx] = ov;
        rc[idx] = chi;
        rp[idx] = v && !ov && (chi < cur_thr);
        rs[idx] = stepn[15:0];
        rl[idx] = 8'(stepn * 3);
        rh[idx] = {11{stepn[15:0]}};
        for (int j = 0; j < N_COORD; j++) coord_i[j*VAL_W +: VAL_W] = cx[j][VAL_W-1:0];
        for (int r = 0; r < N_COMP; r++)
            for (int j = 0; j < N_TERM; j++)
                coef_i[(r*N_TERM + j)*VAL_W +: VAL_W] = ck[r][j][VAL_W-1:0];
        in_valid_i = v;
        sector_i   = rs[idx];
        layers_i   = rl[idx];
        hits_i     = rh[idx];
        thr_load_i = ld;
        thr_i      = CHI_W'(thr);
        stepn++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0);
    endtask

    // R9: loads follow a drain of more than LAT idle cycles.
    task automatic load_thr(input longint t);
        idle(12);
        drive(1'b0, 1'b1, t);
    endtask

    initial begin
        #4ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rv[i] = 1'b0;
        rst_n = 1'b0; in_valid_i = 1'b0; coord_i = '0; coef_i = '0;
        sector_i = '0; layers_i = '0; hits_i = '0; thr_load_i = 1'b0; thr_i = '0;
        repeat (3) @(negedge clk);
        // R10: reset state of the result outputs.
        chk("R10 out_valid", longint'(out_valid_o), 0);
        chk("R10 pass", longint'(pass_o), 0);
        chk("R10 ovf", longint'(ovf_o), 0);
        chk("R10 chi2", longint'(chi2_o), 0);
        rst_n = 1'b1;

        // R9: reset threshold 0 rejects even a zero chi-square.
        clear_vec();
        drive(1'b1, 1'b0, 0);

        // R1 R2: offset column only, including fractional parts floored.
        load_thr(1000);
        for (int k = -40; k <= 40; k++) begin
            clear_vec();
            for (int r = 0; r < N_COMP; r++) ck[r][N_COORD] = (k + 3*r) * 256 + 37*r - 100;
            drive(1'b1, 1'b0, 0);
        end

        // R8: valid gaps with random data on idle cycles.
        load_thr(64'd1 << 41);
        for (int i = 0; i < 300; i++) begin
            rand_vec(12, 12);
            drive((i % 3) != 0, 1'b0, 0);
        end

        // R1 R4 R5 R6: back-to-back sweep over coordinate ranges.
        for (int i = 0; i < 1500; i++) begin
            rand_vec(4 + (i % 9), 12);
            drive(1'b1, 1'b0, 0);
        end

        // R3: full-range values, mostly overflowing.
        load_thr((64'd1 << 57) - 1);
        for (int i = 0; i < 300; i++) begin
            if (i % 2 == 0) rand_vec(27, 27);
            else            rand_vec(27, 6);
            drive(1'b1, 1'b0, 0);
        end

        // R3: narrowing limits at both ends.
        clear_vec(); ck[0][0] = -(1 << 26);     cx[0] = 256; drive(1'b1, 1'b0, 0);
        clear_vec(); ck[0][0] = -(1 << 26);     cx[0] = 257; drive(1'b1, 1'b0, 0);
        clear_vec(); ck[0][0] = (1 << 26) - 1;  cx[0] = 256; drive(1'b1, 1'b0, 0);
        clear_vec(); ck[0][0] = (1 << 26) - 1;  cx[0] = 257; drive(1'b1, 1'b0, 0);

        // R5: chi-square equal to the threshold fails, one below passes.
        load_thr(25);
        clear_vec(); ck[0][N_COORD] = 5 * 256; drive(1'b1, 1'b0, 0);
        load_thr(26);
        clear_vec(); ck[0][N_COORD] = 5 * 256; drive(1'b1, 1'b0, 0);
        clear_vec(); ck[2][N_COORD] = -5 * 256; drive(1'b1, 1'b0, 0);

        idle(12);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule